// File: doc/BRIEF.md
# LIN Transmit Bit-Error Monitor

This block sits beside a LIN transmitter and checks that the bus carries the bit being driven. It reads the bus back through the receive pin, passes it through a synchronizer and an optional inversion, and compares it with the transmit bit once per bit time. The bit time is split into sixteen oversampling ticks. The transmitter marks the first tick of each bit. In standard mode the comparison takes place at the end of the bit. In fast mode it takes place earlier, at one of two selectable ticks.

A mismatch sets a sticky error flag, and only a write-one-to-clear pulse clears that flag. While the flag is set, the block can hold the transmit pin recessive, block transmit DMA requests and raise an interrupt. Each of these actions has its own enable. The block also gates the transmit and receive DMA request lines with their enable bits. Frame building, baud timing and break generation take place outside the block.

Top module: `lin_biterr_mon`

## Requirements
- R1: After reset `bit_err_o` and `irq_o` are 0, and no comparison takes place until a tick arrives with `bit_start_i` high.
- R2: A tick with `bit_start_i` high is sample 1. Each further tick advances the sample number by one, up to 16. A tick after sample 16 that has no `bit_start_i` is idle and makes no comparison. With `fast_mode_i`=0 the single comparison of a bit is made on sample 16.
- R3: With `fast_mode_i`=1 the comparison is made on sample 9 when `late_pt_i`=0 and on sample 13 when `late_pt_i`=1. No other sample is compared.
- R4: `rxd_i` passes through two flip-flops. It is then XORed with `rx_inv_i` (1 means inverted). A mismatch is a compared sample whose resulting value differs from `tx_data_i`.
- R5: A mismatch sets `bit_err_o` on the next cycle. The flag stays set until a cycle with `err_clr_i`=1 and no mismatch. When a mismatch and the clear fall in the same cycle, the flag ends up set.
- R6: With `lin_en_i`=0 no mismatch is detected, the pin is not forced and DMA requests are not blocked.
- R7: `irq_o` is 1 exactly when `bit_err_o`=1 and `err_irq_en_i`=1.
- R8: `txd_o` equals `tx_data_i`, except that it is 1 (recessive) while `lin_en_i`, `tx_stop_i` and `bit_err_o` are all 1.
- R9: `tx_dma_req_o` is 0 while `lin_en_i`=1, `dma_stop_i`=1 and either `bit_err_o` or `pbus_err_i` is 1. When `dma_stop_i`=0 these flags have no effect on it.
- R10: `tx_dma_req_o` follows `tx_dma_req_i` only while `tx_dma_en_i`=1, and `rx_dma_req_o` follows `rx_dma_req_i` only while `rx_dma_en_i`=1. Clearing either enable drops its request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_en_i | input | 1 | LIN mode active |
| fast_mode_i | input | 1 | 0 standard, 1 fast comparison |
| late_pt_i | input | 1 | Fast sample point: 0 sample 9, 1 sample 13 |
| rx_inv_i | input | 1 | Invert receive pin |
| tx_stop_i | input | 1 | Hold pin recessive while error set |
| dma_stop_i | input | 1 | Block transmit DMA on error flags |
| err_irq_en_i | input | 1 | Bit-error interrupt enable |
| samp_tick_i | input | 1 | One pulse per sixteenth of a bit |
| bit_start_i | input | 1 | Marks the tick that is sample 1 |
| tx_data_i | input | 1 | Bit being transmitted |
| rxd_i | input | 1 | Raw receive pin |
| pbus_err_i | input | 1 | Physical bus error flag |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| tx_dma_req_i | input | 1 | Raw transmit DMA request |
| rx_dma_req_i | input | 1 | Raw receive DMA request |
| txd_o | output | 1 | Final transmit pin level |
| bit_err_o | output | 1 | Sticky bit-error flag |
| irq_o | output | 1 | Bit-error interrupt request |
| tx_dma_req_o | output | 1 | Gated transmit DMA request |
| rx_dma_req_o | output | 1 | Gated receive DMA request |

## Verification
Two events can land on the same clock edge: a mismatch found at the compare tick and the software clear of the flag. The bench drives the clear pulse at random on tick cycles, so it often falls on the compare sample of a bit that has a mismatch. A directed bit also forces this case. The bench model gives the set priority, and the flag is checked one cycle later. The bench also rechecks the pin forcing and the DMA gating right after each change of the flag, so that both follow the updated flag.

// File: rtl/lin_bem_pkg.sv
package lin_bem_pkg;
  // sample number (1-based) at which a bit is compared
  function automatic int unsigned cmp_point(input logic fast, input logic late,
                                            input int unsigned n_samp,
                                            input int unsigned early_pt,
                                            input int unsigned late_pt);
    if (!fast) return n_samp;
    return late ? late_pt : early_pt;
  endfunction
endpackage

// File: rtl/lin_bem_sync.sv
module lin_bem_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lin_bem_sampler.sv
module lin_bem_sampler
  import lin_bem_pkg::*;
#(
  parameter int unsigned SAMPLES  = 16,
  parameter int unsigned EARLY_PT = 9,
  parameter int unsigned LATE_PT  = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bit_start_i,
  input  logic fast_i,
  input  logic late_i,
  output logic cmp_stb_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLES + 1);

  logic [CNT_W-1:0] cnt_q, cur, target;

  // 0 = idle, otherwise number of the last sample seen
  always_comb begin
    if (bit_start_i)                                  cur = CNT_W'(1);
    else if (cnt_q == '0 || cnt_q == CNT_W'(SAMPLES)) cur = '0;
    else                                              cur = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cur;
  end

  assign target    = CNT_W'(cmp_point(fast_i, late_i, SAMPLES, EARLY_PT, LATE_PT));
  assign cmp_stb_o = tick_i && (cur != '0) && (cur == target);
endmodule

// File: rtl/lin_bem_gate.sv
module lin_bem_gate (
  input  logic lin_en_i,
  input  logic tx_stop_i,
  input  logic dma_stop_i,
  input  logic err_i,
  input  logic pbus_err_i,
  input  logic tx_data_i,
  input  logic tx_dma_en_i,
  input  logic rx_dma_en_i,
  input  logic tx_dma_req_i,
  input  logic rx_dma_req_i,
  output logic txd_o,
  output logic tx_dma_req_o,
  output logic rx_dma_req_o
);
  logic force_rec, dma_block;

  assign force_rec    = lin_en_i && tx_stop_i && err_i;
  assign dma_block    = lin_en_i && dma_stop_i && (err_i || pbus_err_i);
  assign txd_o        = force_rec ? 1'b1 : tx_data_i;
  assign tx_dma_req_o = tx_dma_req_i && tx_dma_en_i && !dma_block;
  assign rx_dma_req_o = rx_dma_req_i && rx_dma_en_i;
endmodule

// File: rtl/lin_biterr_mon.sv
module lin_biterr_mon #(
  parameter int unsigned SAMPLES     = 16,
  parameter int unsigned EARLY_PT    = 9,
  parameter int unsigned LATE_PT     = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lin_en_i,
  input  logic fast_mode_i,
  input  logic late_pt_i,
  input  logic rx_inv_i,
  input  logic tx_stop_i,
  input  logic dma_stop_i,
  input  logic err_irq_en_i,
  input  logic samp_tick_i,
  input  logic bit_start_i,
  input  logic tx_data_i,
  input  logic rxd_i,
  input  logic pbus_err_i,
  input  logic err_clr_i,
  input  logic tx_dma_en_i,
  input  logic rx_dma_en_i,
  input  logic tx_dma_req_i,
  input  logic rx_dma_req_i,
  output logic txd_o,
  output logic bit_err_o,
  output logic irq_o,
  output logic tx_dma_req_o,
  output logic rx_dma_req_o
);
  logic rx_sync, rx_val, cmp_stb, miss, err_set, err_q;

  lin_bem_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_sync)
  );

  lin_bem_sampler #(.SAMPLES(SAMPLES), .EARLY_PT(EARLY_PT), .LATE_PT(LATE_PT)) u_samp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (samp_tick_i),
    .bit_start_i(bit_start_i),
    .fast_i     (fast_mode_i),
    .late_i     (late_pt_i),
    .cmp_stb_o  (cmp_stb)
  );

  assign rx_val  = rx_sync ^ rx_inv_i;
  assign miss    = rx_val != tx_data_i;
  assign err_set = lin_en_i && cmp_stb && miss;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set)   err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign bit_err_o = err_q;
  assign irq_o     = err_q && err_irq_en_i;

  lin_bem_gate u_gate (
    .lin_en_i    (lin_en_i),
    .tx_stop_i   (tx_stop_i),
    .dma_stop_i  (dma_stop_i),
    .err_i       (err_q),
    .pbus_err_i  (pbus_err_i),
    .tx_data_i   (tx_data_i),
    .tx_dma_en_i (tx_dma_en_i),
    .rx_dma_en_i (rx_dma_en_i),
    .tx_dma_req_i(tx_dma_req_i),
    .rx_dma_req_i(rx_dma_req_i),
    .txd_o       (txd_o),
    .tx_dma_req_o(tx_dma_req_o),
    .rx_dma_req_o(rx_dma_req_o)
  );
endmodule

// File: rtl/lin_bem_chk.sv
module lin_bem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lin_en_i,
  input logic tx_stop_i,
  input logic dma_stop_i,
  input logic err_irq_en_i,
  input logic pbus_err_i,
  input logic err_clr_i,
  input logic tx_dma_en_i,
  input logic rx_dma_en_i,
  input logic cmp_stb,
  input logic miss,
  input logic txd_o,
  input logic bit_err_o,
  input logic irq_o,
  input logic tx_dma_req_o,
  input logic rx_dma_req_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i) !rst_ni |=> !bit_err_o);

  assert_set_on_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_en_i && cmp_stb && miss) |=> bit_err_o);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_err_o && !err_clr_i) |=> bit_err_o);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_err_o && err_clr_i && !(lin_en_i && cmp_stb && miss)) |=> !bit_err_o);

  assert_no_set_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_err_o && !lin_en_i) |=> !bit_err_o);

  assert_irq_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (bit_err_o && err_irq_en_i));

  assert_txd_rec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_en_i && tx_stop_i && bit_err_o) |-> txd_o);

  assert_dma_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_en_i && dma_stop_i && (bit_err_o || pbus_err_i)) |-> !tx_dma_req_o);

  assert_tx_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_dma_en_i |-> !tx_dma_req_o);

  assert_rx_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dma_en_i |-> !rx_dma_req_o);
endmodule

bind lin_biterr_mon lin_bem_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lin_en_i    (lin_en_i),
  .tx_stop_i   (tx_stop_i),
  .dma_stop_i  (dma_stop_i),
  .err_irq_en_i(err_irq_en_i),
  .pbus_err_i  (pbus_err_i),
  .err_clr_i   (err_clr_i),
  .tx_dma_en_i (tx_dma_en_i),
  .rx_dma_en_i (rx_dma_en_i),
  .cmp_stb     (cmp_stb),
  .miss        (miss),
  .txd_o       (txd_o),
  .bit_err_o   (bit_err_o),
  .irq_o       (irq_o),
  .tx_dma_req_o(tx_dma_req_o),
  .rx_dma_req_o(rx_dma_req_o)
);

// File: tb/lin_biterr_mon_test.sv
module lin_biterr_mon_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic lin_en = 0, fast = 0, late = 0, inv = 0, tx_stop = 0, dma_stop = 0, irq_en = 0;
  logic tick = 0, bstart = 0, tx_data = 1, rxd = 1, pbus = 0, clr = 0;
  logic tx_en = 0, rx_en = 0, tx_req = 0, rx_req = 0;
  logic txd, berr, irq, tx_req_o, rx_req_o;

  int unsigned nchk = 0, nfail = 0;
  logic exp_flag = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lin_biterr_mon uut (
    .clk_i(clk), .rst_ni(rst_ni), .lin_en_i(lin_en), .fast_mode_i(fast), .late_pt_i(late),
    .rx_inv_i(inv), .tx_stop_i(tx_stop), .dma_stop_i(dma_stop), .err_irq_en_i(irq_en),
    .samp_tick_i(tick), .bit_start_i(bstart), .tx_data_i(tx_data), .rxd_i(rxd),
    .pbus_err_i(pbus), .err_clr_i(clr), .tx_dma_en_i(tx_en), .rx_dma_en_i(rx_en),
    .tx_dma_req_i(tx_req), .rx_dma_req_i(rx_req), .txd_o(txd), .bit_err_o(berr),
    .irq_o(irq), .tx_dma_req_o(tx_req_o), .rx_dma_req_o(rx_req_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int cmp_at(input logic f, input logic l);
    return !f ? 16 : (l ? 13 : 9);
  endfunction

  function automatic logic exp_txd(input logic d);
    return (lin_en && tx_stop && exp_flag) ? 1'b1 : d;
  endfunction

  function automatic logic exp_txreq();
    return tx_req && tx_en && !(lin_en && dma_stop && (exp_flag || pbus));
  endfunction

  task automatic check_outs();
    check("R5 flag", berr, exp_flag);
    check("R7 irq", irq, exp_flag && irq_en);
    check("R8 txd", txd, exp_txd(tx_data));
    check("R9/R10 tx dma", tx_req_o, exp_txreq());
    check("R10 rx dma", rx_req_o, rx_req && rx_en);
  endtask

  // one sample slot: rxd settles 4 edges before the tick edge (covers R4 sync)
  task automatic slot(input int k, input logic rx_raw, input logic do_clr, input logic start);
    logic hit;
    @(negedge clk);
    rxd = rx_raw; tick = 0; bstart = 0; clr = 0;
    repeat (3) @(negedge clk);
    tick = 1; bstart = start; clr = do_clr;
    hit = lin_en && start !== 1'bx && (k == cmp_at(fast, late)) && ((rx_raw ^ inv) != tx_data);
    if (hit) exp_flag = 1;
    else if (do_clr) exp_flag = 0;
    @(negedge clk);
    tick = 0; bstart = 0; clr = 0;
    check_outs();
  endtask

  task automatic rand_side();
    tx_stop = 1'($urandom); dma_stop = 1'($urandom); irq_en = 1'($urandom);
    pbus = ($urandom % 4) == 0; tx_en = 1'($urandom); rx_en = 1'($urandom);
    tx_req = 1'($urandom); rx_req = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1ea5));
    repeat (3) @(negedge clk);
    check("R1 reset flag", berr, 1'b0);
    check("R1 reset irq", irq, 1'b0);
    rst_ni = 1;

    // R1/R2: ticks without any bit start make no comparison
    lin_en = 1; irq_en = 1; tx_data = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); rxd = 1; tick = 0;
      repeat (3) @(negedge clk);
      tick = 1; @(negedge clk); tick = 0;
    end
    check("R1 idle no compare", berr, 1'b0);

    // R2 standard: mismatch only on sample 16 -> error; then idle tick mismatch ignored
    fast = 0; tx_data = 1;
    for (int k = 1; k <= 16; k++) slot(k, (k == 16) ? 1'b0 : 1'b1, 1'b0, k == 1);
    check("R2 std sample16", berr, 1'b1);
    slot(1, 1'b1, 1'b1, 1'b1);
    for (int k = 2; k <= 16; k++) slot(k, (k < 16) ? 1'b0 : 1'b1, 1'b0, 1'b0);
    check("R2 std early samples ignored", berr, 1'b0);
    slot(17, 1'b0, 1'b0, 1'b0);
    check("R2 idle after 16", berr, 1'b0);

    // R3: fast, mismatch only on sample 13
    for (int l = 0; l < 2; l++) begin
      fast = 1; late = 1'(l); exp_flag = berr;
      for (int k = 1; k <= 16; k++) slot(k, (k == 13) ? 1'b0 : 1'b1, k == 1, k == 1);
      check(l ? "R3 late point hit" : "R3 early point miss", berr, 1'(l));
    end

    // R4 inversion: raw 0 inverted equals tx 1 -> no error
    fast = 0; inv = 1;
    for (int k = 1; k <= 16; k++) slot(k, 1'b0, k == 1, k == 1);
    check("R4 inverted match", berr, 1'b0);
    inv = 0;

    // R5 priority: clear on same tick as mismatch
    slot(1, 1'b1, 1'b0, 1'b1);
    for (int k = 2; k <= 16; k++) slot(k, (k == 16) ? 1'b0 : 1'b1, k == 16, 1'b0);
    check("R5 set beats clear", berr, 1'b1);

    // R6: LIN off, mismatch everywhere, no error
    slot(1, 1'b1, 1'b1, 1'b1); lin_en = 0;
    for (int k = 2; k <= 16; k++) slot(k, 1'b0, 1'b0, 1'b0);
    check("R6 lin off", berr, 1'b0);

    // R8/R9 directed with flag set
    lin_en = 1; tx_data = 1;
    for (int k = 1; k <= 16; k++) slot(k, 1'b0, 1'b0, k == 1);
    tx_data = 0; tx_stop = 1; dma_stop = 1; tx_en = 1; tx_req = 1; pbus = 0;
    #1 check("R8 forced recessive", txd, 1'b1);
    check("R9 dma blocked", tx_req_o, 1'b0);
    dma_stop = 0; #1 check("R9 dma stop off", tx_req_o, 1'b1);
    tx_en = 0; #1 check("R10 tx en drop", tx_req_o, 1'b0);
    rx_en = 1; rx_req = 1; #1 check("R10 rx on", rx_req_o, 1'b1);
    rx_en = 0; #1 check("R10 rx en drop", rx_req_o, 1'b0);

    // random bits
    for (int b = 0; b < 400; b++) begin
      lin_en = ($urandom % 8) != 0; fast = 1'($urandom); late = 1'($urandom);
      inv = 1'($urandom); tx_data = 1'($urandom);
      for (int k = 1; k <= 16; k++) begin
        logic r;
        rand_side();
        r = (($urandom % 5) == 0) ? ~(tx_data ^ inv) : (tx_data ^ inv);
        slot(k, r, ($urandom % 10) < 3, k == 1);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule